// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block sends the complete contents of a 128-byte array over a shared open-drain data line. It sends continuously, without start or stop framing. A separate slow clock (`vclk_i`) paces the stream. That clock is brought into the system clock domain through a synchronizer, and each of its rising edges moves the stream forward by one bit. Every byte goes out as eight data bits, most significant first, followed by one slot in which the line is released. After the last location the stream returns to location 0 and keeps going.

After reset the line stays released for the first nine `vclk_i` rising edges, and real data starts on the tenth. A mode controller uses `en_i` to gate the streamer. It pulses `restart_i` to start again from the MSB of location 0 with no quiet period. The array sits outside the block. It is read combinationally through `byte_addr_o` and `rd_data_i`.

Top module: `serial_stream_tx`

## Requirements
- R1: Each synchronized rising edge of `vclk_i` advances the stream by exactly one bit slot, and bits 7 down to 0 of the addressed byte are sent in that order, MSB first.
- R2: The slot after bit 0 of every byte is a null slot in which `sda_oe_o` is 0, so the line floats high.
- R3: After reset, `sda_oe_o` stays 0 for the first nine `vclk_i` rising edges. The tenth edge sends the MSB of location 0.
- R4: `byte_addr_o` increments by one after each null slot and wraps from 127 to 0 without a break.
- R5: While `en_i` is 0, `sda_oe_o` is 0 and `vclk_i` edges are ignored. Byte address and bit position are held, and streaming resumes from that point when `en_i` returns to 1.
- R6: A one-cycle `restart_i` sets `byte_addr_o` to 0 and the bit position to the MSB, cancels any remaining quiet period and releases the line until the next edge. A `vclk_i` edge that falls in the same cycle as `restart_i` is discarded.
- R7: `sda_oe_o` is registered. It changes only in response to a synchronized edge, a restart or disable, and it follows `vclk_i` by at least two system clocks. After reset, `sda_oe_o` is 0 and `byte_addr_o` is 0.
- R8: The line is open drain. `sda_oe_o`=1 pulls it low to send a 0 bit, and a 1 bit leaves `sda_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up) |
| vclk_i | input | 1 | Asynchronous bit clock for the stream |
| en_i | input | 1 | Streaming enable from the mode controller |
| restart_i | input | 1 | Restart at the MSB of location 0 |
| rd_data_i | input | 8 | Byte read from the array at `byte_addr_o` |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| byte_addr_o | output | 7 | Current byte address, also the array read address |

## Verification
The bit-advance path and the restart path can act in the same system clock cycle. This happens when a restart pulse arrives just as the synchronized edge of `vclk_i` reaches the sequencer. The bench provokes this by raising `vclk_i`, counting the two synchronizer stages and asserting `restart_i` in the cycle the edge pulse is present. The check that follows must find the line released at address 0. The next edge must then carry the MSB of location 0, which is a 0 bit. If the discarded edge had been applied, the line would instead be driven low right after the restart.

// File: rtl/stream_pkg.sv
package stream_pkg;
  typedef enum logic {
    PH_QUIET = 1'b0,
    PH_RUN   = 1'b1
  } phase_e;
endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vclk_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], vclk_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/stream_seq.sv
module stream_seq
  import stream_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned QUIET_EDGES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              oe_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SLOT  = DATA_W + 1;
  localparam int unsigned BIT_W = $clog2(SLOT);
  localparam int unsigned QW    = (QUIET_EDGES > 1) ? $clog2(QUIET_EDGES) : 1;

  phase_e            phase_q;
  logic [QW-1:0]     quiet_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              oe_q;

  logic [DATA_W-1:0] data_sh;
  logic              cur_bit;
  logic              at_null;

  assign data_sh = rd_data_i << bit_q;
  assign cur_bit = data_sh[DATA_W-1];
  assign at_null = (bit_q == BIT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_QUIET;
      quiet_q <= '0;
      bit_q   <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
    end else if (restart_i) begin
      // restart wins over a coincident edge
      phase_q <= PH_RUN;
      bit_q   <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
    end else if (!en_i) begin
      oe_q    <= 1'b0;
    end else if (step_i) begin
      if (phase_q == PH_QUIET) begin
        oe_q    <= 1'b0;
        quiet_q <= quiet_q + 1'b1;
        if (quiet_q == QW'(QUIET_EDGES - 1)) phase_q <= PH_RUN;
      end else if (at_null) begin
        oe_q   <= 1'b0;
        bit_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        oe_q  <= ~cur_bit;
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign oe_o   = oe_q;
  assign addr_o = addr_q;

  a_r3_quiet_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_QUIET |-> !oe_q);

  a_r1_bit_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && !restart_i && phase_q == PH_RUN && !at_null)
      |=> bit_q == BIT_W'($past(bit_q) + 1'b1));

  a_r2_null_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && !restart_i && phase_q == PH_RUN && at_null)
      |=> (!oe_q && bit_q == '0));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && !restart_i && phase_q == PH_RUN && at_null && addr_q == '1)
      |=> addr_q == '0);

  a_r5_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!oe_q && $stable(addr_q) && $stable(bit_q)));

  a_r6_restart_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (addr_q == '0 && bit_q == '0 && !oe_q && phase_q == PH_RUN));

  a_r7_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && en_i && !restart_i) |=> $stable(oe_q));
endmodule

// File: rtl/serial_stream_tx.sv
module serial_stream_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned QUIET_EDGES = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_i,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] byte_addr_o
);
  logic step;

  vclk_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vclk_i (vclk_i),
    .rise_o (step)
  );

  stream_seq #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .QUIET_EDGES (QUIET_EDGES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .en_i      (en_i),
    .restart_i (restart_i),
    .rd_data_i (rd_data_i),
    .oe_o      (sda_oe_o),
    .addr_o    (byte_addr_o)
  );
endmodule

// File: tb/serial_stream_tx_tb_top.sv
module serial_stream_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk = 1'b0;
  logic       en = 1'b1;
  logic       restart = 1'b0;
  logic [7:0] rd_data;
  logic       sda_oe;
  logic [6:0] byte_addr;

  int n_chk = 0;
  int n_fail = 0;

  // reference stream position
  int m_quiet = 0;
  int m_bit   = 0;
  int m_addr  = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(a * 29) ^ 8'h5A;
  endfunction

  assign rd_data = mem_byte(int'(byte_addr));

  serial_stream_tx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vclk_i      (vclk),
    .en_i        (en),
    .restart_i   (restart),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe),
    .byte_addr_o (byte_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one vclk period, then compare against the reference
  task automatic pulse(input string req);
    logic prev_oe;
    logic exp_oe;
    prev_oe = sda_oe;
    @(negedge clk) vclk = 1'b1;
    @(negedge clk);
    check(sda_oe == prev_oe, "R7 latency", int'(sda_oe), int'(prev_oe));
    repeat (4) @(negedge clk);
    vclk = 1'b0;
    repeat (5) @(negedge clk);
    exp_oe = 1'b0;
    if (en) begin
      if (m_quiet < 9) m_quiet++;
      else if (m_bit == 8) begin
        m_bit = 0;
        m_addr = (m_addr + 1) % 128;
      end else begin
        exp_oe = ~mem_byte(m_addr)[7 - m_bit];
        m_bit++;
      end
    end
    check(sda_oe == exp_oe, req, int'(sda_oe), int'(exp_oe));
    check(int'(byte_addr) == m_addr, req, int'(byte_addr), m_addr);
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R7 reset oe", int'(sda_oe), 0);
    check(byte_addr == 7'd0, "R7 reset addr", int'(byte_addr), 0);
  endtask

  task automatic t_quiet;
    for (int i = 0; i < 9; i++) pulse("R3 quiet");
    pulse("R3 first MSB");
  endtask

  task automatic t_bytes;
    for (int i = 0; i < 26; i++) begin
      if (m_bit == 8) pulse("R2 null / R4 incr");
      else pulse("R1 R8 data bit");
    end
  endtask

  task automatic t_wrap;
    while (!(m_addr == 127 && m_bit == 8)) pulse("R1 stream");
    pulse("R4 wrap");
    check(byte_addr == 7'd0, "R4 wrap addr", int'(byte_addr), 0);
    for (int i = 0; i < 9; i++) pulse("R4 after wrap");
  endtask

  task automatic t_disable;
    // move to a slot that pulls the line low
    int guard = 0;
    while (sda_oe == 1'b0 && guard < 40) begin
      pulse("R1 seek");
      guard++;
    end
    check(sda_oe == 1'b1, "R5 precondition", int'(sda_oe), 1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sda_oe == 1'b0, "R5 release", int'(sda_oe), 0);
    for (int i = 0; i < 3; i++) pulse("R5 ignored");
    @(negedge clk) en = 1'b1;
    for (int i = 0; i < 10; i++) pulse("R5 resume");
  endtask

  task automatic t_restart;
    pulse("R1 pre");
    pulse("R1 pre");
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    m_addr = 0; m_bit = 0; m_quiet = 9;
    check(sda_oe == 1'b0, "R6 restart oe", int'(sda_oe), 0);
    check(byte_addr == 7'd0, "R6 restart addr", int'(byte_addr), 0);
    for (int i = 0; i < 12; i++) pulse("R6 from origin");
  endtask

  task automatic t_collide;
    @(negedge clk) vclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_addr = 0; m_bit = 0; m_quiet = 9;
    check(sda_oe == 1'b0, "R6 collide oe", int'(sda_oe), 0);
    check(byte_addr == 7'd0, "R6 collide addr", int'(byte_addr), 0);
    repeat (3) @(negedge clk);
    vclk = 1'b0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R6 edge dropped", int'(sda_oe), 0);
    pulse("R6 MSB after collide");
    pulse("R6 bit after collide");
  endtask

  task automatic t_reset_restart_quiet;
    // restart right after reset skips the quiet period
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_addr = 0; m_bit = 0; m_quiet = 0;
    check(sda_oe == 1'b0, "R7 reset oe again", int'(sda_oe), 0);
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    m_quiet = 9;
    pulse("R6 no quiet");
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_bytes();
    t_wrap();
    t_disable();
    t_restart();
    t_collide();
    t_reset_restart_quiet();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule